// File: doc/BRIEF.md
# SDRAM Mode Register Load Sequencer

This block sits between the initialisation logic of a DDR-style SDRAM controller and the command bus. A request carries the wanted burst length code, burst ordering, CAS latency code and a DLL-enable flag. The block first checks the codes. It rejects any reserved value with a one-cycle error pulse and issues no command. For a legal request it builds the register words and drives one or two LOAD MODE commands, each as a one-cycle strobe with a bank-select pair and a row-address word.

When the DLL is to be enabled, the extended register is written first. A base-register write with the DLL-reset bit set follows it. When the DLL flag is clear, only the base register is written, with normal operating mode. No load goes out while the all-banks-idle input is low: the sequencer waits in place until that input rises. After every load, a programmable wait of `MRD_CYCLES` clocks runs before the next load or the done pulse.

Top module: `sdram_mode_loader`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cmdLoadMode`, `seqDone` and `seqError` are low.
- R2: A request whose burst code is not 001/010/011, or whose CAS code is not 010/110, gives `seqError` high for exactly the cycle after the request edge. No load strobe and no done pulse follow.
- R3: A base-register load drives `cmdBank` = 00. Its `cmdAddr` carries the burst code in bits 2..0, the interleave flag in bit 3 (1 = interleaved, 0 = sequential) and the CAS code in bits 6..4.
- R4: With the DLL flag set, the first load uses `cmdBank` = 01 and an all-zero word (bit 0 clear = DLL enabled). It is followed by a base load with bit 8 set (DLL reset).
- R5: With the DLL flag clear, exactly one load is issued: a base load with bits 12..7 all zero.
- R6: A load strobe is issued only after a clock edge at which `banksIdle` was high. While `banksIdle` stays low, the pending load is held, and it issues on the edge that first sees the input high.
- R7: Consecutive load strobes are at least `MRD_CYCLES`+1 cycles apart, and `seqDone` rises exactly `MRD_CYCLES` cycles after the final load strobe.
- R8: A request presented while a sequence is in progress has no effect: no error, no change to the command words, no extra load.
- R9: `cmdLoadMode`, `seqDone` and `seqError` are single-cycle pulses.
- R10: A request presented in the cycle where `seqDone` is high is accepted. Its first load strobe appears two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, sampled when the sequencer is idle |
| reqBurstLen | input | 3 | Burst length code (001=2, 010=4, 011=8) |
| reqInterleave | input | 1 | Burst ordering: 1 interleaved, 0 sequential |
| reqCasCode | input | 3 | CAS latency code (010=2, 110=2.5) |
| reqDllEnable | input | 1 | Enable the DLL and reset it |
| banksIdle | input | 1 | All banks idle, no burst in flight |
| cmdLoadMode | output | 1 | LOAD MODE command strobe |
| cmdBank | output | 2 | Bank-select pair: 00 base, 01 extended |
| cmdAddr | output | ROW_BITS | Register word on the row-address lines |
| seqDone | output | 1 | Sequence finished, wait elapsed |
| seqError | output | 1 | Request rejected for a reserved code |

## Verification
The done pulse of one sequence can fall in the same cycle as the acceptance of the next request. The bench provokes this by raising a new request exactly in the done cycle. It judges the case by the second sequence's load strobe appearing two cycles later, with its own word, and by a second done pulse. A second coincidence is the idle gate meeting the end of the wait. The bench holds `banksIdle` low past the point where the load would go out, then raises it on a chosen cycle, and checks that the strobe comes on the very next cycle and no earlier.

// File: rtl/sdram_mode_pkg.sv
package sdram_mode_pkg;

  // Control-to-datapath strobes, one bit per datapath action.
  typedef struct packed {
    logic latchReq;
    logic loadExt;
    logic loadBase;
    logic pulseErr;
    logic pulseDone;
  } seqStrobes_t;

  localparam logic [1:0] BANK_BASE = 2'b00;
  localparam logic [1:0] BANK_EXT  = 2'b01;
  localparam int DLL_RESET_BIT = 8;

  function automatic logic burstCodeLegal(input logic [2:0] code);
    return (code == 3'b001) || (code == 3'b010) || (code == 3'b011);
  endfunction

  function automatic logic casCodeLegal(input logic [2:0] code);
    return (code == 3'b010) || (code == 3'b110);
  endfunction

endpackage

// File: rtl/sdram_mode_dp.sv
module sdram_mode_dp
  import sdram_mode_pkg::*;
#(
  parameter int ROW_BITS = 13
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          reqBurstLen,
  input  logic                reqInterleave,
  input  logic [2:0]          reqCasCode,
  input  logic                reqDllEnable,
  input  seqStrobes_t         strobes,
  output logic                reqOk,
  output logic                cmdLoadMode,
  output logic [1:0]          cmdBank,
  output logic [ROW_BITS-1:0] cmdAddr,
  output logic                seqDone,
  output logic                seqError
);

  logic [2:0] blHeld;
  logic       ilHeld;
  logic [2:0] casHeld;
  logic       dllHeld;
  logic [ROW_BITS-1:0] baseWord;
  logic [ROW_BITS-1:0] extWord;

  assign reqOk = burstCodeLegal(reqBurstLen) && casCodeLegal(reqCasCode);

  // Base word: burst code, ordering, latency; DLL reset rides on bit 8.
  always_comb begin
    baseWord = '0;
    baseWord[2:0] = blHeld;
    baseWord[3]   = ilHeld;
    baseWord[6:4] = casHeld;
    baseWord[DLL_RESET_BIT] = dllHeld;
  end

  // Extended word: bit 0 clear keeps the DLL enabled, all else default.
  assign extWord = '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blHeld  <= '0;
      ilHeld  <= 1'b0;
      casHeld <= '0;
      dllHeld <= 1'b0;
    end else if (strobes.latchReq) begin
      blHeld  <= reqBurstLen;
      ilHeld  <= reqInterleave;
      casHeld <= reqCasCode;
      dllHeld <= reqDllEnable;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdLoadMode <= 1'b0;
      cmdBank     <= BANK_BASE;
      cmdAddr     <= '0;
      seqDone     <= 1'b0;
      seqError    <= 1'b0;
    end else begin
      cmdLoadMode <= strobes.loadExt | strobes.loadBase;
      seqDone     <= strobes.pulseDone;
      seqError    <= strobes.pulseErr;
      if (strobes.loadExt) begin
        cmdBank <= BANK_EXT;
        cmdAddr <= extWord;
      end else if (strobes.loadBase) begin
        cmdBank <= BANK_BASE;
        cmdAddr <= baseWord;
      end
    end
  end

endmodule

// File: rtl/sdram_mode_ctl.sv
module sdram_mode_ctl
  import sdram_mode_pkg::*;
#(
  parameter int MRD_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqDllEnable,
  input  logic        reqOk,
  input  logic        banksIdle,
  output seqStrobes_t strobes
);

  localparam int CNT_W = $clog2(MRD_CYCLES + 1);
  localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(MRD_CYCLES);

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_HOLD} seqState_t;

  seqState_t state, stateN;
  logic phaseExt, phaseExtN;
  logic [CNT_W-1:0] waitCnt;

  always_comb begin
    strobes   = '0;
    stateN    = state;
    phaseExtN = phaseExt;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqOk) begin
            strobes.latchReq = 1'b1;
            phaseExtN = reqDllEnable;
            stateN = ST_ARM;
          end else begin
            strobes.pulseErr = 1'b1;
          end
        end
      end
      ST_ARM: begin
        if (banksIdle) begin
          strobes.loadExt  = phaseExt;
          strobes.loadBase = !phaseExt;
          stateN = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (waitCnt == CNT_W'(1)) begin
          if (phaseExt) begin
            phaseExtN = 1'b0;
            stateN = ST_ARM;
          end else begin
            strobes.pulseDone = 1'b1;
            stateN = ST_IDLE;
          end
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseExt <= 1'b0;
      waitCnt  <= '0;
    end else begin
      state    <= stateN;
      phaseExt <= phaseExtN;
      if (state == ST_ARM && banksIdle) begin
        waitCnt <= WAIT_LOAD;
      end else if (state == ST_HOLD && waitCnt != '0) begin
        waitCnt <= waitCnt - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/sdram_mode_loader.sv
module sdram_mode_loader
  import sdram_mode_pkg::*;
#(
  parameter int ROW_BITS   = 13,
  parameter int MRD_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [2:0]          reqBurstLen,
  input  logic                reqInterleave,
  input  logic [2:0]          reqCasCode,
  input  logic                reqDllEnable,
  input  logic                banksIdle,
  output logic                cmdLoadMode,
  output logic [1:0]          cmdBank,
  output logic [ROW_BITS-1:0] cmdAddr,
  output logic                seqDone,
  output logic                seqError
);

  seqStrobes_t strobes;
  logic reqOk;

  sdram_mode_ctl #(.MRD_CYCLES(MRD_CYCLES)) u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqDllEnable (reqDllEnable),
    .reqOk        (reqOk),
    .banksIdle    (banksIdle),
    .strobes      (strobes)
  );

  sdram_mode_dp #(.ROW_BITS(ROW_BITS)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .reqBurstLen   (reqBurstLen),
    .reqInterleave (reqInterleave),
    .reqCasCode    (reqCasCode),
    .reqDllEnable  (reqDllEnable),
    .strobes       (strobes),
    .reqOk         (reqOk),
    .cmdLoadMode   (cmdLoadMode),
    .cmdBank       (cmdBank),
    .cmdAddr       (cmdAddr),
    .seqDone       (seqDone),
    .seqError      (seqError)
  );

endmodule

// File: rtl/sdram_mode_loader_chk.sv
module sdram_mode_loader_chk
  import sdram_mode_pkg::*;
#(
  parameter int ROW_BITS   = 13,
  parameter int MRD_CYCLES = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                banksIdle,
  input logic                cmdLoadMode,
  input logic [1:0]          cmdBank,
  input logic [ROW_BITS-1:0] cmdAddr,
  input logic                seqDone,
  input logic                seqError
);

  localparam int GAP_W = $clog2(MRD_CYCLES + 2) + 1;
  localparam logic [ROW_BITS-1:0] BASE_USED = ROW_BITS'(9'h17F);

  logic [GAP_W-1:0] gapCnt;
  logic extPending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt     <= GAP_W'(MRD_CYCLES + 1);
      extPending <= 1'b0;
    end else begin
      if (cmdLoadMode) gapCnt <= GAP_W'(1);
      else if (gapCnt <= GAP_W'(MRD_CYCLES)) gapCnt <= gapCnt + GAP_W'(1);
      if (cmdLoadMode && cmdBank == BANK_EXT) extPending <= 1'b1;
      else if (cmdLoadMode && cmdBank == BANK_BASE) extPending <= 1'b0;
    end
  end

  p_idle_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmdLoadMode |-> $past(banksIdle));

  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmdLoadMode |=> !cmdLoadMode);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);

  p_err_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    seqError |=> !seqError);

  p_err_silent_r2: assert property (@(posedge clk) disable iff (!rstN)
    seqError |-> (!cmdLoadMode && !seqDone));

  p_bank_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdLoadMode |-> (cmdBank == BANK_BASE || cmdBank == BANK_EXT));

  p_ext_word_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdLoadMode && cmdBank == BANK_EXT) |-> (cmdAddr == '0));

  p_dll_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdLoadMode && cmdBank == BANK_BASE && cmdAddr[DLL_RESET_BIT]) |-> extPending);

  p_base_opmode_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdLoadMode && cmdBank == BANK_BASE) |-> ((cmdAddr & ~BASE_USED) == '0));

  p_base_codes_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdLoadMode && cmdBank == BANK_BASE) |->
      (burstCodeLegal(cmdAddr[2:0]) && casCodeLegal(cmdAddr[6:4])));

  p_spacing_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdLoadMode |-> (gapCnt > GAP_W'(MRD_CYCLES)));

  p_done_wait_r7: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> (gapCnt == GAP_W'(MRD_CYCLES) && !extPending));

endmodule

bind sdram_mode_loader sdram_mode_loader_chk #(
  .ROW_BITS   (ROW_BITS),
  .MRD_CYCLES (MRD_CYCLES)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .banksIdle   (banksIdle),
  .cmdLoadMode (cmdLoadMode),
  .cmdBank     (cmdBank),
  .cmdAddr     (cmdAddr),
  .seqDone     (seqDone),
  .seqError    (seqError)
);

// File: tb/sdram_mode_loader_tb.sv
module sdram_mode_loader_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MRD = 2;
  localparam int RB = 13;
  localparam int NVEC = 8;

  // {burst[2:0], interleave, cas[2:0], dll, expectError}
  localparam logic [8:0] VEC [NVEC] = '{
    {3'b001, 1'b0, 3'b010, 1'b0, 1'b0},
    {3'b011, 1'b1, 3'b110, 1'b1, 1'b0},
    {3'b010, 1'b0, 3'b110, 1'b0, 1'b0},
    {3'b000, 1'b0, 3'b010, 1'b0, 1'b1},
    {3'b010, 1'b1, 3'b011, 1'b0, 1'b1},
    {3'b111, 1'b0, 3'b110, 1'b1, 1'b1},
    {3'b001, 1'b1, 3'b010, 1'b1, 1'b0},
    {3'b100, 1'b0, 3'b000, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqBurstLen = '0;
  logic reqInterleave = 1'b0;
  logic [2:0] reqCasCode = '0;
  logic reqDllEnable = 1'b0;
  logic banksIdle = 1'b1;
  logic cmdLoadMode;
  logic [1:0] cmdBank;
  logic [RB-1:0] cmdAddr;
  logic seqDone;
  logic seqError;

  int checks = 0;
  int failures = 0;

  int nLoads, nDone, nErr, errK;
  int loadK [4];
  logic [1:0] loadBank [4];
  logic [RB-1:0] loadAddr [4];
  int doneK [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_mode_loader #(.ROW_BITS(RB), .MRD_CYCLES(MRD)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBurstLen(reqBurstLen),
    .reqInterleave(reqInterleave), .reqCasCode(reqCasCode),
    .reqDllEnable(reqDllEnable), .banksIdle(banksIdle),
    .cmdLoadMode(cmdLoadMode), .cmdBank(cmdBank), .cmdAddr(cmdAddr),
    .seqDone(seqDone), .seqError(seqError)
  );

  function automatic logic [RB-1:0] expBase(input logic [2:0] bl, input logic il,
                                            input logic [2:0] cas, input logic dll);
    logic [RB-1:0] w;
    w = '0;
    w[2:0] = bl;
    w[3] = il;
    w[6:4] = cas;
    w[8] = dll;
    return w;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic driveReq(input logic [7:0] f);
    reqBurstLen   = f[7:5];
    reqInterleave = f[4];
    reqCasCode    = f[3:1];
    reqDllEnable  = f[0];
    reqValid      = 1'b1;
  endtask

  // Issue one request, then sample NS negedges (k = 1..NS), recording events.
  task automatic runSeq(input logic [7:0] f, input int injK, input logic [7:0] injF,
                        input int idleRiseK, input int ns);
    @(negedge clk);
    driveReq(f);
    banksIdle = (idleRiseK > 0) ? 1'b0 : 1'b1;
    nLoads = 0; nDone = 0; nErr = 0; errK = 0;
    for (int k = 1; k <= ns; k++) begin
      @(negedge clk);
      reqValid = 1'b0;
      if (k == injK) driveReq(injF);
      if (k == idleRiseK) banksIdle = 1'b1;
      if (cmdLoadMode) begin
        if (nLoads < 4) begin
          loadK[nLoads] = k;
          loadBank[nLoads] = cmdBank;
          loadAddr[nLoads] = cmdAddr;
        end
        nLoads++;
      end
      if (seqDone) begin
        if (nDone < 2) doneK[nDone] = k;
        nDone++;
      end
      if (seqError) begin
        errK = k;
        nErr++;
      end
    end
    reqValid = 1'b0;
    banksIdle = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 load in reset", int'(cmdLoadMode), 0);
    chk("R1 done in reset", int'(seqDone), 0);
    chk("R1 error in reset", int'(seqError), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 load after reset", int'(cmdLoadMode), 0);
    chk("R1 error after reset", int'(seqError), 0);

    // Vector table: R2, R3, R4, R5, R7, R9
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] bl;
      logic il, dll, expErr;
      logic [2:0] cas;
      bl = VEC[i][8:6]; il = VEC[i][5]; cas = VEC[i][4:2];
      dll = VEC[i][1]; expErr = VEC[i][0];
      runSeq({bl, il, cas, dll}, 0, 8'h00, 0, 14);
      if (expErr) begin
        chk("R2 error count", nErr, 1);
        chk("R2 error cycle", errK, 1);
        chk("R2 no load", nLoads, 0);
        chk("R2 no done", nDone, 0);
      end else begin
        chk("R2 no error", nErr, 0);
        chk("R9 done once", nDone, 1);
        if (dll) begin
          chk("R4 load count", nLoads, 2);
          chk("R4 ext first cycle", loadK[0], 2);
          chk("R4 ext bank", int'(loadBank[0]), 1);
          chk("R4 ext word", int'(loadAddr[0]), 0);
          chk("R7 base spacing", loadK[1], 3 + MRD);
          chk("R4 base bank", int'(loadBank[1]), 0);
          chk("R4 R3 base word", int'(loadAddr[1]), int'(expBase(bl, il, cas, 1'b1)));
          chk("R7 done cycle", doneK[0], 3 + 2 * MRD);
        end else begin
          chk("R5 load count", nLoads, 1);
          chk("R5 load cycle", loadK[0], 2);
          chk("R3 base bank", int'(loadBank[0]), 0);
          chk("R3 R5 base word", int'(loadAddr[0]), int'(expBase(bl, il, cas, 1'b0)));
          chk("R7 done cycle", doneK[0], 2 + MRD);
        end
      end
    end

    // R6: banks busy holds the load until the input rises at k=6
    runSeq({3'b010, 1'b1, 3'b010, 1'b0}, 0, 8'h00, 6, 14);
    chk("R6 load count", nLoads, 1);
    chk("R6 load waits for idle", loadK[0], 7);
    chk("R6 done after wait", doneK[0], 7 + MRD);

    // R8: reserved request mid-sequence is ignored (no error, same loads)
    runSeq({3'b011, 1'b0, 3'b110, 1'b1}, 3, {3'b000, 1'b0, 3'b000, 1'b0}, 0, 14);
    chk("R8 no error mid-sequence", nErr, 0);
    chk("R8 load count", nLoads, 2);
    chk("R8 done count", nDone, 1);

    // R8: legal but different request mid-sequence leaves the words unchanged
    runSeq({3'b001, 1'b0, 3'b010, 1'b1}, 4, {3'b011, 1'b1, 3'b110, 1'b0}, 0, 14);
    chk("R8 load count legal inject", nLoads, 2);
    chk("R8 base word unchanged", int'(loadAddr[1]),
        int'(expBase(3'b001, 1'b0, 3'b010, 1'b1)));
    chk("R8 single done", nDone, 1);

    // R10: new request in the done cycle is accepted
    runSeq({3'b010, 1'b0, 3'b010, 1'b0}, 2 + MRD, {3'b011, 1'b1, 3'b110, 1'b0}, 0, 16);
    chk("R10 done of first", doneK[0], 2 + MRD);
    chk("R10 load count", nLoads, 2);
    chk("R10 second load cycle", loadK[1], 4 + MRD);
    chk("R10 second word", int'(loadAddr[1]), int'(expBase(3'b011, 1'b1, 3'b110, 1'b0)));
    chk("R10 second done", doneK[1], 4 + 2 * MRD);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule